// File: doc/BRIEF.md
# Datapath ALU with Output Shifter

This block is the arithmetic heart of a microcoded datapath. In each datapath cycle it takes a 32-bit operand from the holding register (side A) and a 32-bit operand from the selected source bus (side B). Control bits from the current microinstruction shape both operands, pick a logic or add function and optionally shift the result. The shifted value goes back onto the result bus, where the register that is to be written picks it up.

Each operand has its own enable, and side A can also be complemented. The adder takes a carry-in, so that A+B+1 and B−A can be formed in a single pass: B−A is obtained with the invert on A and a carry-in of 1. The shifter after the function stage offers two moves: a byte-wide logical left shift and a one-bit arithmetic right shift. Asking for both at once is a microcode error. In that case the unshifted value is passed on and an error output is raised.

A sign flag and a zero flag are derived from the final result. Both are captured on the clock edge that closes the datapath cycle, so branch logic sees them stable in the following cycle. There are no states or transitions: the function path is purely combinational and the only storage is the flag pair.

Top module: `dpath_alu_unit`

## Requirements
- R1: When `ena_h` is 0, operand A is zero before inversion and the function. When `ena_b` is 0, operand B is zero before the function.
- R2: When `inv_h` is 1, operand A is bitwise complemented after its enable is applied, so `ena_h`=0 with `inv_h`=1 gives all ones.
- R3: `fn_sel` picks the function: 2'b00 gives A AND B, 2'b01 gives A OR B, 2'b10 gives NOT B (A is not used), and 2'b11 gives the sum.
- R4: The sum is A + B + `cin` modulo 2^32. `cin` has no effect on the three logic functions.
- R5: With `sh_left8`=1 and `sh_right1`=0, `res` is the function value shifted left by 8 bits, and its bits 7:0 are zero.
- R6: With `sh_right1`=1 and `sh_left8`=0, `res` is the function value shifted right by one bit, and bit 31 keeps its previous value.
- R7: When both shift controls are 1, `res` is the unshifted function value and `shift_err`=1. Otherwise `shift_err`=0. With neither shift control set, `res` is the function value.
- R8: At each rising clock edge outside reset, `flag_n` takes bit 31 of `res`, and `flag_z` takes 1 exactly when `res` is zero.
- R9: While `rst_n` is low, `flag_n` and `flag_z` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock; flags update on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| opnd_h | input | 32 | Operand A, from the holding register |
| opnd_b | input | 32 | Operand B, from the selected bus |
| ena_h | input | 1 | Enable for operand A (0 forces zero) |
| ena_b | input | 1 | Enable for operand B (0 forces zero) |
| inv_h | input | 1 | Complement operand A |
| fn_sel | input | 2 | Function select: AND, OR, NOT B, SUM |
| cin | input | 1 | Carry into the adder |
| sh_left8 | input | 1 | Request a logical left shift by one byte |
| sh_right1 | input | 1 | Request an arithmetic right shift by one bit |
| res | output | 32 | Shifted result |
| shift_err | output | 1 | Both shift requests asserted |
| flag_n | output | 1 | Registered sign of the result |
| flag_z | output | 1 | Registered zero indication of the result |

## Verification
The assertions take for granted that the control inputs are stable, known levels across each whole cycle and change only between rising edges. The flag properties compare the flags against the result of the previous cycle, which assumes that the inputs do not move while the edge is sampled. The bench drives every input on the falling edge and holds it for a full period, so each rising edge sees one settled microinstruction. Besides plain random stimulus, it deliberately issues the illegal two-shift request and operand patterns that give a zero or negative result, so the conditional properties are really exercised.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_NOTB = 2'b10,
        FN_SUM  = 2'b11
    } alu_fn_e;

    typedef enum logic [1:0] {
        SH_NONE  = 2'b00,
        SH_LEFT  = 2'b01,
        SH_RIGHT = 2'b10,
        SH_BAD   = 2'b11
    } shift_req_e;

endpackage

// File: rtl/alu_opnd_gate.sv
module alu_opnd_gate #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    input  logic         enable,
    input  logic         invert,
    output logic [W-1:0] dout
);
    logic [W-1:0] gated;

    always_comb begin
        gated = enable ? din : '0;
        dout  = gated ^ {W{invert}};
    end
endmodule

// File: rtl/alu_logic_core.sv
module alu_logic_core
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  alu_fn_e      fn,
    input  logic         carry_in,
    output logic [W-1:0] fout
);
    logic [W-1:0] sum;

    always_comb begin
        sum = op_a + op_b + W'(carry_in);
        unique case (fn)
            FN_AND:  fout = op_a & op_b;
            FN_OR:   fout = op_a | op_b;
            FN_NOTB: fout = ~op_b;
            FN_SUM:  fout = sum;
            default: fout = '0;
        endcase
    end
endmodule

// File: rtl/alu_post_shift.sv
module alu_post_shift
    import dp_alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int SHAMT = 8
) (
    input  logic [W-1:0] din,
    input  logic         left_req,
    input  logic         right_req,
    output logic [W-1:0] dout,
    output logic         bad_req
);
    shift_req_e   req;
    logic [W-1:0] lft;
    logic [W-1:0] rgt;

    always_comb begin
        req = shift_req_e'({right_req, left_req});
        lft = {din[W-SHAMT-1:0], {SHAMT{1'b0}}};
        rgt = {din[W-1], din[W-1:1]};
        bad_req = 1'b0;
        unique case (req)
            SH_NONE:  dout = din;
            SH_LEFT:  dout = lft;
            SH_RIGHT: dout = rgt;
            SH_BAD: begin
                dout    = din;
                bad_req = 1'b1;
            end
            default:  dout = din;
        endcase
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] value,
    output logic         neg_q,
    output logic         zero_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_q  <= 1'b0;
            zero_q <= 1'b0;
        end else begin
            neg_q  <= value[W-1];
            zero_q <= (value == '0);
        end
    end
endmodule

// File: rtl/dpath_alu_unit.sv
module dpath_alu_unit
    import dp_alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int SHAMT = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opnd_h,
    input  logic [W-1:0] opnd_b,
    input  logic         ena_h,
    input  logic         ena_b,
    input  logic         inv_h,
    input  logic [1:0]   fn_sel,
    input  logic         cin,
    input  logic         sh_left8,
    input  logic         sh_right1,
    output logic [W-1:0] res,
    output logic         shift_err,
    output logic         flag_n,
    output logic         flag_z
);
    logic [W-1:0] a_eff;
    logic [W-1:0] b_eff;
    logic [W-1:0] f_val;

    alu_opnd_gate #(.W(W)) u_gate_a (
        .din(opnd_h), .enable(ena_h), .invert(inv_h), .dout(a_eff)
    );

    alu_opnd_gate #(.W(W)) u_gate_b (
        .din(opnd_b), .enable(ena_b), .invert(1'b0), .dout(b_eff)
    );

    alu_logic_core #(.W(W)) u_core (
        .op_a(a_eff), .op_b(b_eff), .fn(alu_fn_e'(fn_sel)),
        .carry_in(cin), .fout(f_val)
    );

    alu_post_shift #(.W(W), .SHAMT(SHAMT)) u_shift (
        .din(f_val), .left_req(sh_left8), .right_req(sh_right1),
        .dout(res), .bad_req(shift_err)
    );

    alu_flag_reg #(.W(W)) u_flags (
        .clk(clk), .rst_n(rst_n), .value(res),
        .neg_q(flag_n), .zero_q(flag_z)
    );
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ena_h,
    input logic         ena_b,
    input logic         inv_h,
    input logic [1:0]   fn_sel,
    input logic         cin,
    input logic         sh_left8,
    input logic         sh_right1,
    input logic [W-1:0] res,
    input logic         shift_err,
    input logic         flag_n,
    input logic         flag_z
);
    logic no_sh;
    assign no_sh = !sh_left8 && !sh_right1;

    assert_and_zero_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ena_b && fn_sel == 2'b00 && no_sh) |-> res == '0);

    assert_inv_zero_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ena_h && inv_h && fn_sel == 2'b01 && no_sh) |-> res == '1);

    assert_notb_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ena_b && fn_sel == 2'b10 && no_sh) |-> res == '1);

    assert_sum_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ena_h && !inv_h && !ena_b && fn_sel == 2'b11 && no_sh) |-> res == W'(cin));

    assert_left_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_left8 && !sh_right1) |-> res[7:0] == 8'h00);

    assert_right_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_right1 && !sh_left8) |-> res[W-1] == res[W-2]);

    assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_left8 && sh_right1) |-> shift_err);

    assert_err_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_left8 && sh_right1) |-> !shift_err);

    assert_flag_n_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> flag_n == $past(res[W-1]));

    assert_flag_z_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> flag_z == ($past(res) == '0));
endmodule

bind dpath_alu_unit dp_alu_chk #(.W(W)) u_alu_chk (
    .clk(clk), .rst_n(rst_n), .ena_h(ena_h), .ena_b(ena_b), .inv_h(inv_h),
    .fn_sel(fn_sel), .cin(cin), .sh_left8(sh_left8), .sh_right1(sh_right1),
    .res(res), .shift_err(shift_err), .flag_n(flag_n), .flag_z(flag_z)
);

// File: tb/tb_dpath_alu_unit.sv
module tb_dpath_alu_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_h = '0, opnd_b = '0;
    logic        ena_h = 1'b0, ena_b = 1'b0, inv_h = 1'b0, cin = 1'b0;
    logic [1:0]  fn_sel = 2'b00;
    logic        sh_left8 = 1'b0, sh_right1 = 1'b0;
    logic [31:0] res;
    logic        shift_err, flag_n, flag_z;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [31:0] seed = 32'h1234_5679;

    typedef struct {
        logic [31:0] r;
        logic        e;
    } exp_t;
    exp_t sb[$];

    dpath_alu_unit dut (
        .clk(clk), .rst_n(rst_n), .opnd_h(opnd_h), .opnd_b(opnd_b),
        .ena_h(ena_h), .ena_b(ena_b), .inv_h(inv_h), .fn_sel(fn_sel),
        .cin(cin), .sh_left8(sh_left8), .sh_right1(sh_right1),
        .res(res), .shift_err(shift_err), .flag_n(flag_n), .flag_z(flag_z)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model written from R1..R7
    function automatic exp_t model(input logic [31:0] h, input logic [31:0] b,
                                   input logic eh, input logic eb, input logic ih,
                                   input logic [1:0] f, input logic c,
                                   input logic sl, input logic sr);
        logic [31:0] a, bb, v;
        exp_t o;
        a  = eh ? h : 32'h0;
        if (ih) a = ~a;
        bb = eb ? b : 32'h0;
        case (f)
            2'b00: v = a & bb;
            2'b01: v = a | bb;
            2'b10: v = ~bb;
            default: v = a + bb + {31'h0, c};
        endcase
        o.e = sl && sr;
        if (sl && !sr)      o.r = v << 8;
        else if (sr && !sl) o.r = {v[31], v[31:1]};
        else                o.r = v;
        return o;
    endfunction

    task automatic drive(input logic [31:0] h, input logic [31:0] b,
                         input logic eh, input logic eb, input logic ih,
                         input logic [1:0] f, input logic c,
                         input logic sl, input logic sr);
        @(negedge clk);
        opnd_h = h; opnd_b = b; ena_h = eh; ena_b = eb; inv_h = ih;
        fn_sel = f; cin = c; sh_left8 = sl; sh_right1 = sr;
        sb.push_back(model(h, b, eh, eb, ih, f, c, sl, sr));
    endtask

    // monitor: 1 ns after the edge, res still reflects this cycle's inputs
    // and the flags have just captured it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk("R1-R6 res", res, e.r);
                chk("R7 shift_err", {31'h0, shift_err}, {31'h0, e.e});
                chk("R8 flag_n", {31'h0, flag_n}, {31'h0, e.r[31]});
                chk("R8 flag_z", {31'h0, flag_z}, {31'h0, e.r == 32'h0});
            end
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        opnd_h = 32'hFFFF_FFFF;
        opnd_b = 32'h8000_0000;
        fn_sel = 2'b10;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 flag_n in reset", {31'h0, flag_n}, 32'h0);
        chk("R9 flag_z in reset", {31'h0, flag_z}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: enables force zero
        drive(32'hF0F0_1234, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
        drive(32'hF0F0_1234, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        // R2: invert after enable
        drive(32'h1234_5678, 32'h0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        drive(32'h0F0F_0F0F, 32'hFFFF_0000, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
        // R3: each function
        drive(32'hAAAA_5555, 32'hFF00_FF00, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        drive(32'hAAAA_5555, 32'hFF00_FF00, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
        drive(32'hAAAA_5555, 32'hFF00_FF00, 1'b1, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0);
        // R4: sums, carry-in, B-A, wrap to zero, cin ignored on logic
        drive(32'd100, 32'd23, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0);
        drive(32'd100, 32'd23, 1'b1, 1'b1, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0);
        drive(32'd5, 32'd12, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0);
        drive(32'd12, 32'd5, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0);
        drive(32'hFFFF_FFFF, 32'h1, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0);
        drive(32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0);
        drive(32'h0000_00F0, 32'h0000_000F, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
        // R5: byte left shift
        drive(32'h12345678, 32'h0, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0, 1'b1, 1'b0);
        drive(32'hFF00_00FF, 32'h0, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0, 1'b1, 1'b0);
        // R6: arithmetic right shift, negative and positive
        drive(32'h8000_0002, 32'h0, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b1);
        drive(32'h7FFF_FFFF, 32'h0, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b1);
        drive(32'h0000_0001, 32'h0, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 1'b1);
        // R7: both shifts -> unshifted and error
        drive(32'h8765_4321, 32'h0, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0, 1'b1, 1'b1);
        drive(32'h0, 32'h0, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 1'b1, 1'b1);
        // random mix covering R1..R8
        for (int i = 0; i < 400; i++) begin
            logic [31:0] h, b, k;
            h = rnd(); b = rnd(); k = rnd();
            if (k[12:10] == 3'b000) b = -h;
            drive(h, b, k[0], k[1], k[2], k[4:3], k[5], k[6] & k[8], k[7] & k[9]);
        end
        @(negedge clk);
        @(negedge clk);
        // R9: flags return to 0 in reset
        opnd_h = 32'h8000_0000; ena_h = 1'b1; fn_sel = 2'b01;
        sh_left8 = 1'b0; sh_right1 = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R9 flag_n after reset", {31'h0, flag_n}, 32'h0);
        chk("R9 flag_z after reset", {31'h0, flag_z}, 32'h0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule